// File: doc/BRIEF.md
# Supply Voltage Monitor Control

This block is the digital side of a programmable supply-voltage monitor. Software programs an 8-bit control word with an enable bit, a rise/fall direction bit and a 4-bit trip level. The block compares digitised voltage samples against the threshold that the level selects. Level codes 0 to 14 compare the supply sample against a parameterised table that increases with the code. Level 15 compares an external-pin sample against a fixed reference code.

Each time the monitor is enabled it first waits through a settling interval. Only after that may a trip raise the sticky event flag. The flag stays set until software strobes a clear. A persisting trip condition does not fire again until a valid sample has shown the condition false. The interrupt request is the flag gated by an interrupt-enable input. A reference-stable input from the bandgap model is synchronised into a read-only status bit.

Top module: `vmon_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, and evt_flag and irq are 0.
- R2: A write (wr_en high at a clock edge) loads wr_data bit 7 (direction), bit 4 (enable) and bits 3:0 (trip level) into rd_data at the same bit positions from the next cycle on. Written values of bits 6 and 5 are ignored.
- R3: rd_data bit 6 follows ref_ok_in through a two-flop synchroniser, so a change on the input shows two clock edges later.
- R4: rd_data bit 5 (ready) reads 1 only while enabled. It is set SETTLE_CYC clock edges after the edge that writes enable from 0 to 1, counting that edge. It clears at the same edge that writes enable to 0, and the count restarts on every new enable.
- R5: With direction 1, a trip is a sample greater than or equal to the threshold. With direction 0, a trip is a sample less than or equal to the threshold. Equality trips in both cases.
- R6: Level codes 0 to 14 compare vdd_sample with threshold 40+10*code (default table). Code 15 compares ext_sample with EXT_REF (default 128), and vdd_sample is then ignored.
- R7: Samples are evaluated only at edges where sample_vld is 1.
- R8: No event is raised while ready reads 0, including while the monitor is disabled.
- R9: evt_flag sets at the edge of a tripping valid sample and stays set until a flag_clr edge. A new trip in the same edge takes precedence over the clear.
- R10: After an event, further tripping samples raise no new event until a valid sample has evaluated as not tripping.
- R11: irq is registered: at each edge it takes the new evt_flag value ANDed with irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write data |
| rd_data | output | 8 | Control/status word read data |
| flag_clr | input | 1 | Event flag clear strobe |
| irq_en | input | 1 | Interrupt enable |
| ref_ok_in | input | 1 | Asynchronous reference-stable indication |
| vdd_sample | input | SAMPLE_W | Digitised supply voltage |
| ext_sample | input | SAMPLE_W | Digitised external-pin voltage |
| sample_vld | input | 1 | Sample valid strobe |
| evt_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets samples exactly at the threshold in both directions. A design with a strict comparison would miss these trips. It also counts the settling interval edge by edge: an off-by-one counter would show ready a cycle early or late, and a design without the ready gate would fire during settling. Level 15 is driven with a high supply and a low external sample, and a design that still compared the supply would fire there. Held trip conditions across a flag clear check the re-arm rule, since a design without it would set the flag again at once. A long random phase with rare writes checks the disable and re-enable paths against a cycle-accurate model.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  localparam int CTRL_W   = 8;
  localparam int BIT_DIR  = 7;
  localparam int BIT_REF  = 6;
  localparam int BIT_RDY  = 5;
  localparam int BIT_EN   = 4;
  localparam int LVL_W    = 4;
  localparam int N_LEVELS = 1 << LVL_W;
  localparam logic [LVL_W-1:0] EXT_CODE = LVL_W'(N_LEVELS - 1);
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_async};
  end

  assign q_sync = sh_q[STAGES-1];
endmodule

// File: rtl/vmon_settle.sv
module vmon_settle #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_nxt,
  output logic ready
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  // Counts edges while the next enable is high; a low enable clears the
  // count and ready together, so each new enable starts a full interval.
  always_ff @(posedge clk) begin
    if (rst || !en_nxt) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_q <= 1'b1;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/vmon_detect.sv
module vmon_detect
  import vmon_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter logic [SAMPLE_W-1:0] EXT_REF = 8'd128,
  parameter logic [15*SAMPLE_W-1:0] TRIP_TABLE = {
    8'd180, 8'd170, 8'd160, 8'd150, 8'd140, 8'd130, 8'd120, 8'd110,
    8'd100, 8'd90,  8'd80,  8'd70,  8'd60,  8'd50,  8'd40}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_up,
  input  logic [LVL_W-1:0]    lvl,
  input  logic                ready,
  input  logic [SAMPLE_W-1:0] vdd_sample,
  input  logic [SAMPLE_W-1:0] ext_sample,
  input  logic                sample_vld,
  input  logic                flag_clr,
  input  logic                irq_en,
  output logic                evt_flag,
  output logic                irq
);
  logic [SAMPLE_W-1:0] thr_tab [N_LEVELS];

  for (genvar i = 0; i < N_LEVELS; i++) begin : g_thr
    if (i == N_LEVELS - 1) begin : g_ext
      assign thr_tab[i] = EXT_REF;
    end else begin : g_tab
      assign thr_tab[i] = TRIP_TABLE[i*SAMPLE_W +: SAMPLE_W];
    end
  end

  logic [SAMPLE_W-1:0] mon, thr;
  logic trip, fire, armed_q, flag_q, flag_d, irq_q;

  always_comb begin
    mon    = (lvl == EXT_CODE) ? ext_sample : vdd_sample;
    thr    = thr_tab[lvl];
    trip   = dir_up ? (mon >= thr) : (mon <= thr);
    fire   = sample_vld && ready && armed_q && trip;
    flag_d = fire || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (!ready)          armed_q <= 1'b1;
      else if (fire)       armed_q <= 1'b0;
      else if (sample_vld && !trip) armed_q <= 1'b1;
      flag_q <= flag_d;
      irq_q  <= flag_d && irq_en;
    end
  end

  assign evt_flag = flag_q;
  assign irq      = irq_q;
endmodule

// File: rtl/vmon_ctrl.sv
module vmon_ctrl
  import vmon_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int SETTLE_CYC  = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [SAMPLE_W-1:0] EXT_REF = 8'd128,
  parameter logic [15*SAMPLE_W-1:0] TRIP_TABLE = {
    8'd180, 8'd170, 8'd160, 8'd150, 8'd140, 8'd130, 8'd120, 8'd110,
    8'd100, 8'd90,  8'd80,  8'd70,  8'd60,  8'd50,  8'd40}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_data,
  input  logic                flag_clr,
  input  logic                irq_en,
  input  logic                ref_ok_in,
  input  logic [SAMPLE_W-1:0] vdd_sample,
  input  logic [SAMPLE_W-1:0] ext_sample,
  input  logic                sample_vld,
  output logic                evt_flag,
  output logic                irq
);
  logic             dir_q, en_q, en_nxt, ref_sync, ready;
  logic [LVL_W-1:0] lvl_q;
  logic             wr_unused;

  assign wr_unused = ^wr_data[BIT_REF:BIT_RDY];
  assign en_nxt    = wr_en ? wr_data[BIT_EN] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      en_q  <= 1'b0;
      lvl_q <= '0;
    end else if (wr_en) begin
      dir_q <= wr_data[BIT_DIR];
      en_q  <= wr_data[BIT_EN];
      lvl_q <= wr_data[LVL_W-1:0];
    end
  end

  vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(ref_ok_in), .q_sync(ref_sync)
  );

  vmon_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .en_nxt(en_nxt), .ready(ready)
  );

  vmon_detect #(
    .SAMPLE_W(SAMPLE_W), .EXT_REF(EXT_REF), .TRIP_TABLE(TRIP_TABLE)
  ) u_detect (
    .clk(clk), .rst(rst), .dir_up(dir_q), .lvl(lvl_q), .ready(ready),
    .vdd_sample(vdd_sample), .ext_sample(ext_sample),
    .sample_vld(sample_vld), .flag_clr(flag_clr), .irq_en(irq_en),
    .evt_flag(evt_flag), .irq(irq)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_DIR]   = dir_q;
    rd_data[BIT_REF]   = ref_sync;
    rd_data[BIT_RDY]   = ready;
    rd_data[BIT_EN]    = en_q;
    rd_data[LVL_W-1:0] = lvl_q;
  end
endmodule

// File: rtl/vmon_ctrl_chk.sv
module vmon_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       flag_clr,
  input logic       irq_en,
  input logic       sample_vld,
  input logic       evt_flag,
  input logic       irq
);
  assert_wr_fields_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[7] == $past(wr_data[7]) && rd_data[4:0] == $past(wr_data[4:0])));

  assert_ready_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
    rd_data[5] |-> rd_data[4]);

  assert_ready_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[4]) |=> !rd_data[5]);

  assert_evt_needs_vld_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) |-> $past(sample_vld));

  assert_no_evt_unready_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) |-> $past(rd_data[5]));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_flag && !flag_clr) |=> evt_flag);

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> evt_flag);

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    (evt_flag && $past(irq_en)) |-> irq);
endmodule

bind vmon_ctrl vmon_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .flag_clr(flag_clr), .irq_en(irq_en), .sample_vld(sample_vld),
  .evt_flag(evt_flag), .irq(irq)
);

// File: tb/vmon_ctrl_tb.sv
module vmon_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 16;

  logic       clk = 0, rst = 1;
  logic       wr_en = 0, flag_clr = 0, irq_en = 0, ref_ok_in = 0, sample_vld = 0;
  logic [7:0] wr_data = 0, vdd_sample = 0, ext_sample = 0;
  logic [7:0] rd_data;
  logic       evt_flag, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  vmon_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .flag_clr(flag_clr), .irq_en(irq_en), .ref_ok_in(ref_ok_in),
    .vdd_sample(vdd_sample), .ext_sample(ext_sample), .sample_vld(sample_vld),
    .evt_flag(evt_flag), .irq(irq)
  );

  // Behavioural reference model
  bit m_dir, m_en, m_s1, m_s2, m_rdy, m_arm, m_flag, m_irq;
  int m_lvl, m_cnt;

  function automatic int thr_of(int lvl);
    return (lvl == 15) ? 128 : 40 + 10 * lvl;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dir = 0; m_en = 0; m_lvl = 0; m_s1 = 0; m_s2 = 0;
      m_cnt = 0; m_rdy = 0; m_arm = 1; m_flag = 0; m_irq = 0;
    end else begin
      int smp, thr; bit trip, fire, en_n;
      en_n = wr_en ? wr_data[4] : m_en;
      smp  = (m_lvl == 15) ? int'(ext_sample) : int'(vdd_sample);
      thr  = thr_of(m_lvl);
      trip = m_dir ? (smp >= thr) : (smp <= thr);
      fire = sample_vld && m_rdy && m_arm && trip;
      if (!m_rdy) m_arm = 1;
      else if (fire) m_arm = 0;
      else if (sample_vld && !trip) m_arm = 1;
      if (fire) m_flag = 1; else if (flag_clr) m_flag = 0;
      m_irq = m_flag && irq_en;
      if (!en_n) begin m_cnt = 0; m_rdy = 0; end
      else if (!m_rdy) begin
        m_cnt++;
        if (m_cnt == SETTLE) m_rdy = 1;
      end
      m_s2 = m_s1; m_s1 = ref_ok_in;
      if (wr_en) begin m_dir = wr_data[7]; m_en = wr_data[4]; m_lvl = int'(wr_data[3:0]); end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare with the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2", "dir bit", rd_data[7], m_dir);
      chk("R2", "enable bit", rd_data[4], m_en);
      chk("R2", "level field", rd_data[3:0], m_lvl);
      chk("R3", "ref stable bit", rd_data[6], m_s2);
      chk("R4", "ready bit", rd_data[5], m_rdy);
      chk("R9", "event flag", evt_flag, m_flag);
      chk("R11", "irq", irq, m_irq);
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic smp(logic v, logic [7:0] vdd, logic [7:0] ext, logic clr);
    sample_vld = v; vdd_sample = vdd; ext_sample = ext; flag_clr = clr;
    tick();
    sample_vld = 0; flag_clr = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", "rd_data after reset", rd_data, 0);
    chk("R1", "flag after reset", evt_flag, 0);
    chk("R1", "irq after reset", irq, 0);

    ref_ok_in = 1; tick();
    chk("R3", "ref bit after one edge", rd_data[6], 0);
    tick();
    chk("R3", "ref bit after two edges", rd_data[6], 1);

    wr(8'h63);
    chk("R2", "bits 6/5 write ignored", rd_data, 8'h43);

    wr(8'h13);  // enable, dir down, level 3 (threshold 70)
    for (int k = 1; k < SETTLE; k++) begin
      chk("R4", "ready during settle", rd_data[5], 0);
      smp(1, 8'd10, 8'd0, 0);
      chk("R8", "no event while settling", evt_flag, 0);
    end
    chk("R4", "ready after settle", rd_data[5], 1);

    smp(1, 8'd71, 8'd0, 0);
    chk("R5", "above threshold, dir down", evt_flag, 0);
    smp(0, 8'd60, 8'd0, 0);
    chk("R7", "no event without valid", evt_flag, 0);
    smp(1, 8'd70, 8'd0, 0);
    chk("R5", "equal threshold, dir down", evt_flag, 1);
    chk("R11", "irq masked", irq, 0);
    smp(0, 8'd60, 8'd0, 1);
    chk("R9", "flag cleared", evt_flag, 0);
    smp(1, 8'd60, 8'd0, 0);
    chk("R10", "held trip does not refire", evt_flag, 0);
    smp(1, 8'd90, 8'd0, 0);
    irq_en = 1;
    smp(1, 8'd60, 8'd0, 0);
    chk("R10", "refire after rearm", evt_flag, 1);
    chk("R11", "irq with enable", irq, 1);
    smp(1, 8'd60, 8'd0, 1);
    chk("R9", "flag clear on held trip", evt_flag, 0);

    wr(8'h9F);  // dir up, external input
    smp(1, 8'd255, 8'd100, 0);
    chk("R6", "supply ignored in external mode", evt_flag, 0);
    smp(1, 8'd0, 8'd128, 0);
    chk("R6", "external equal reference, dir up", evt_flag, 1);
    smp(0, 8'd0, 8'd0, 1);

    wr(8'h8F);  // disable
    chk("R4", "ready clears with enable", rd_data[5], 0);
    smp(1, 8'd0, 8'd100, 0);
    smp(1, 8'd0, 8'd200, 0);
    chk("R8", "no event while disabled", evt_flag, 0);
    wr(8'h9F);
    smp(1, 8'd0, 8'd200, 0);
    chk("R8", "no event after re-enable before ready", evt_flag, 0);
    chk("R4", "ready restarts", rd_data[5], 0);

    for (int n = 0; n < 4000; n++) begin
      wr_en      = ($urandom % 40) == 0;
      wr_data    = 8'($urandom) | ((($urandom % 6) != 0) ? 8'h10 : 8'h00);
      vdd_sample = 8'($urandom % 200);
      ext_sample = 8'(100 + $urandom % 60);
      sample_vld = $urandom % 2;
      flag_clr   = ($urandom % 8) == 0;
      irq_en     = $urandom % 2;
      if (($urandom % 50) == 0) ref_ok_in = ~ref_ok_in;
      tick();
    end
    wr_en = 0; sample_vld = 0; flag_clr = 0;
    tick();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule